// File: doc/BRIEF.md
# Software-Coherent Write-Through Cache Controller

This block sits between a processor bus and an external memory bus and keeps a small direct-mapped copy of recently read memory. It has no snooping. When another bus master changes memory, the cached copy goes stale and stays stale until software removes it. Software does this with one of two purge requests. The first invalidates the single line that holds a given address. The second clears every line in one clock.

Three paths never allocate a line:

- **Uncached window.** Any address with bit 29 set is sent straight to memory.
- **Atomic test-and-set.** It always makes one read and one write on the memory bus and never looks at the cache.
- **Instruction-only mode.** A static control input limits new allocation to instruction fetches. Data lines that were filled before the mode was set keep hitting.

Writes go through to memory. A write that hits also updates the cached word. A write that misses allocates nothing.

The cache has 64 lines of four 32-bit words. A line fill reads all four words as a burst, starting at word 0. The requested word is returned only after the whole line has arrived.

The processor side uses a valid/ready handshake and holds the request until ready is seen. The memory side holds a request until an acknowledge is returned, and moves one word per acknowledge.

Top module: `cache_purge_ctl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` and `mem_req` are low, and the first read of any cacheable address is a miss.
- R2: A read that hits a valid line raises `cpu_ready` in the same cycle as `cpu_valid`, returns the cached word and makes no memory request.
- R3: A cacheable read miss that allocates makes four memory reads at line base + 0, 4, 8 and 12, in that order. Each read holds its address until acknowledged. The controller then returns the requested word, and later reads of any word of that line hit.
- R4: With `ctl_ionly` = 1, a data read miss makes exactly one memory read of the word and allocates nothing, so repeating it misses again. An instruction fetch miss (`cpu_ifetch` = 1) still fills the line.
- R5: With `ctl_ionly` = 1, data reads to lines filled before it was set still hit.
- R6: An access with address bit 29 = 1 makes exactly one memory transfer and never hits or fills, even when repeated.
- R7: Every write makes one memory write with its address and data. A write hit updates the cached word. A write miss allocates nothing and leaves the line resident at that index in place.
- R8: An atomic access reads the word from memory and returns that value. It then writes back the same value with bit 7 set. It neither reads the cache, updates it nor allocates in it.
- R9: A memory change made by another master is not observed. A hit keeps returning the old cached word until the line is purged.
- R10: A line purge invalidates only the line whose index and tag equal those of `purge_addr`. A purge address with the same index but another tag has no effect, and other lines are untouched.
- R11: A whole-cache purge leaves every line invalid at the next clock edge.
- R12: `cpu_ready` is low in every cycle in which a purge request is asserted. A processor request held across the purge is served afterwards, against the purged state.
- R13: A line purge that matches the line in the same cycle as the final fill acknowledge wins. The line stays invalid, but the processor still receives the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_ionly | input | 1 | Instruction-only allocation mode |
| cpu_valid | input | 1 | Processor request valid, held until ready |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_ifetch | input | 1 | Read is an instruction fetch |
| cpu_atomic | input | 1 | Atomic test-and-set access |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| purge_line_req | input | 1 | Invalidate the line matching purge_addr |
| purge_addr | input | 32 | Address selecting the line to purge |
| purge_all_req | input | 1 | Invalidate every line |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory transfer completes this cycle |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |

## Verification
Two functions can meet in one cycle: a purge request and processor traffic.

- **Purge against a new request.** A purge is raised in the same cycle that a processor request first appears. The bench judges that ready stays low for that cycle. It also checks the resulting miss count: a purge of the target line turns the would-be hit into a four-read fill, while a purge of a different line only costs one cycle.
- **Purge against the last fill beat.** A line purge is timed to coincide with the fourth acknowledge of a fill, and it names the tag being filled rather than the old one. The bench checks that the correct word is still returned. A repeat read must then miss again, and only a third read may hit.

// File: rtl/cpc_pkg.sv
package cpc_pkg;

    localparam int unsigned CPC_AW = 32;
    localparam int unsigned CPC_DW = 32;
    localparam int unsigned TAS_FLAG_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SINGLE,
        ST_WRITE,
        ST_TAS_RD,
        ST_TAS_WR,
        ST_DONE
    } cpc_state_e;

    typedef enum logic [2:0] {
        OP_HIT,
        OP_FILL,
        OP_SINGLE,
        OP_WRITE,
        OP_ATOMIC
    } cpc_op_e;

    typedef struct packed {
        logic write;
        logic ifetch;
        logic atomic;
        logic thru;
    } cpc_req_s;

    // Decide how an accepted request is served.
    function automatic cpc_op_e classify(input cpc_req_s r, input logic hit,
                                         input logic ionly);
        if (r.atomic)            return OP_ATOMIC;
        if (r.write)             return OP_WRITE;
        if (r.thru)              return OP_SINGLE;
        if (hit)                 return OP_HIT;
        if (ionly && !r.ifetch)  return OP_SINGLE;
        return OP_FILL;
    endfunction

    function automatic logic [CPC_DW-1:0] tas_merge(input logic [CPC_DW-1:0] w);
        return w | (CPC_DW'(1) << TAS_FLAG_BIT);
    endfunction

endpackage

// File: rtl/cpc_tag_store.sv
module cpc_tag_store
    import cpc_pkg::*;
#(
    parameter int unsigned LINES = 64,
    parameter int unsigned TAG_W = 22,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] look_idx,
    input  logic [TAG_W-1:0] look_tag,
    output logic             look_hit,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             pline_en,
    input  logic [IDX_W-1:0] pline_idx,
    input  logic [TAG_W-1:0] pline_tag,
    input  logic             pall_en,
    output logic [LINES-1:0] valid_o
);

    logic [TAG_W-1:0] tag_vec [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic             filling;
        logic [TAG_W-1:0] eff_tag;
        logic             kill;

        assign filling = fill_en && (fill_idx == IDX_W'(i));
        // A line being filled is judged by the tag it is about to hold.
        assign eff_tag = filling ? fill_tag : t_q;
        assign kill    = pall_en ||
                         (pline_en && (pline_idx == IDX_W'(i)) && (eff_tag == pline_tag));

        always_ff @(posedge clk) begin
            if (rst)          v_q <= 1'b0;
            else if (kill)    v_q <= 1'b0;
            else if (filling) v_q <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (filling) t_q <= fill_tag;
        end

        assign valid_o[i] = v_q;
        assign tag_vec[i] = t_q;
    end

    assign look_hit = valid_o[look_idx] && (tag_vec[look_idx] == look_tag);

endmodule

// File: rtl/cpc_data_store.sv
module cpc_data_store
    import cpc_pkg::*;
#(
    parameter int unsigned LINES      = 64,
    parameter int unsigned LINE_WORDS = 4,
    localparam int unsigned DEPTH = LINES * LINE_WORDS,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     raddr,
    output logic [CPC_DW-1:0] rdata,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [CPC_DW-1:0] wdata
);

    logic [CPC_DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/cpc_ctrl.sv
module cpc_ctrl
    import cpc_pkg::*;
#(
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned THRU_BIT   = 29,
    localparam int unsigned WRD_W = $clog2(LINE_WORDS),
    localparam int unsigned OFF_W = WRD_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_ionly,
    input  logic              purge_busy,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic              cpu_ifetch,
    input  logic              cpu_atomic,
    input  logic [CPC_AW-1:0] cpu_addr,
    input  logic [CPC_DW-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [CPC_DW-1:0] cpu_rdata,
    output logic [CPC_AW-1:0] look_addr,
    input  logic              look_hit,
    input  logic [CPC_DW-1:0] look_rdata,
    output logic              dat_we,
    output logic [CPC_AW-1:0] dat_addr,
    output logic [CPC_DW-1:0] dat_wdata,
    output logic              fill_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [CPC_AW-1:0] mem_addr,
    output logic [CPC_DW-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [CPC_DW-1:0] mem_rdata
);

    localparam logic [WRD_W-1:0] LAST_WORD = WRD_W'(LINE_WORDS - 1);

    cpc_state_e        st_q, st_d;
    logic [CPC_AW-1:0] req_addr_q;
    logic [CPC_DW-1:0] req_wdata_q;
    logic [CPC_DW-1:0] rsp_q;
    logic [WRD_W-1:0]  cnt_q;
    cpc_req_s          req_in;
    cpc_op_e           op;
    logic              accept;

    assign req_in = '{write: cpu_write, ifetch: cpu_ifetch,
                      atomic: cpu_atomic, thru: cpu_addr[THRU_BIT]};
    assign op        = classify(req_in, look_hit, ctl_ionly);
    assign look_addr = (st_q == ST_IDLE) ? cpu_addr : req_addr_q;
    assign accept    = (st_q == ST_IDLE) && cpu_valid && !purge_busy;

    always_comb begin
        st_d      = st_q;
        cpu_ready = 1'b0;
        cpu_rdata = rsp_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {req_addr_q[CPC_AW-1:2], 2'b00};
        mem_wdata = req_wdata_q;
        dat_we    = 1'b0;
        dat_addr  = req_addr_q;
        dat_wdata = mem_rdata;
        fill_en   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                cpu_rdata = look_rdata;
                if (accept) begin
                    unique case (op)
                        OP_HIT:    cpu_ready = 1'b1;
                        OP_FILL:   st_d = ST_FILL;
                        OP_SINGLE: st_d = ST_SINGLE;
                        OP_WRITE:  st_d = ST_WRITE;
                        OP_ATOMIC: st_d = ST_TAS_RD;
                        default:   st_d = ST_IDLE;
                    endcase
                end
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_addr_q[CPC_AW-1:OFF_W], cnt_q, 2'b00};
                dat_addr = mem_addr;
                if (mem_ack) begin
                    dat_we = 1'b1;
                    if (cnt_q == LAST_WORD) begin
                        fill_en = 1'b1;
                        st_d    = ST_DONE;
                    end
                end
            end
            ST_SINGLE: begin
                mem_req = 1'b1;
                if (mem_ack) st_d = ST_DONE;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                dat_wdata = req_wdata_q;
                if (mem_ack) begin
                    dat_we = look_hit && !req_addr_q[THRU_BIT];
                    st_d   = ST_DONE;
                end
            end
            ST_TAS_RD: begin
                mem_req = 1'b1;
                if (mem_ack) st_d = ST_TAS_WR;
            end
            ST_TAS_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = tas_merge(rsp_q);
                if (mem_ack) st_d = ST_DONE;
            end
            ST_DONE: begin
                cpu_ready = !purge_busy;
                if (!purge_busy) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            cnt_q       <= '0;
            rsp_q       <= '0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) begin
                req_addr_q  <= cpu_addr;
                req_wdata_q <= cpu_wdata;
                cnt_q       <= '0;
            end
            if (st_q == ST_FILL && mem_ack) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == req_addr_q[2 +: WRD_W]) rsp_q <= mem_rdata;
            end
            if ((st_q == ST_SINGLE || st_q == ST_TAS_RD) && mem_ack) rsp_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/cache_purge_ctl.sv
module cache_purge_ctl
    import cpc_pkg::*;
#(
    parameter int unsigned LINES      = 64,
    parameter int unsigned LINE_WORDS = 4,
    parameter int unsigned THRU_BIT   = 29
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_ionly,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_write,
    input  logic              cpu_ifetch,
    input  logic              cpu_atomic,
    input  logic [CPC_AW-1:0] cpu_addr,
    input  logic [CPC_DW-1:0] cpu_wdata,
    output logic [CPC_DW-1:0] cpu_rdata,
    input  logic              purge_line_req,
    input  logic [CPC_AW-1:0] purge_addr,
    input  logic              purge_all_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [CPC_AW-1:0] mem_addr,
    output logic [CPC_DW-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [CPC_DW-1:0] mem_rdata
);

    localparam int unsigned IDX_W = $clog2(LINES);
    localparam int unsigned WRD_W = $clog2(LINE_WORDS);
    localparam int unsigned OFF_W = WRD_W + 2;
    localparam int unsigned TAG_W = CPC_AW - OFF_W - IDX_W;
    localparam int unsigned DAW   = IDX_W + WRD_W;

    logic              purge_busy;
    logic [CPC_AW-1:0] look_addr;
    logic              look_hit;
    logic [CPC_DW-1:0] look_rdata;
    logic              dat_we;
    logic [CPC_AW-1:0] dat_addr;
    logic [CPC_DW-1:0] dat_wdata;
    logic              fill_en;
    logic [LINES-1:0]  line_valid;
    logic              unused_addr_bits;

    assign purge_busy       = purge_line_req || purge_all_req;
    assign unused_addr_bits = ^{purge_addr[OFF_W-1:0], look_addr[1:0], dat_addr[1:0]};

    cpc_ctrl #(
        .LINE_WORDS (LINE_WORDS),
        .THRU_BIT   (THRU_BIT)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .ctl_ionly  (ctl_ionly),
        .purge_busy (purge_busy),
        .cpu_valid  (cpu_valid),
        .cpu_write  (cpu_write),
        .cpu_ifetch (cpu_ifetch),
        .cpu_atomic (cpu_atomic),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rdata  (cpu_rdata),
        .look_addr  (look_addr),
        .look_hit   (look_hit),
        .look_rdata (look_rdata),
        .dat_we     (dat_we),
        .dat_addr   (dat_addr),
        .dat_wdata  (dat_wdata),
        .fill_en    (fill_en),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    cpc_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk       (clk),
        .rst       (rst),
        .look_idx  (look_addr[OFF_W +: IDX_W]),
        .look_tag  (look_addr[CPC_AW-1 -: TAG_W]),
        .look_hit  (look_hit),
        .fill_en   (fill_en),
        .fill_idx  (dat_addr[OFF_W +: IDX_W]),
        .fill_tag  (dat_addr[CPC_AW-1 -: TAG_W]),
        .pline_en  (purge_line_req),
        .pline_idx (purge_addr[OFF_W +: IDX_W]),
        .pline_tag (purge_addr[CPC_AW-1 -: TAG_W]),
        .pall_en   (purge_all_req),
        .valid_o   (line_valid)
    );

    cpc_data_store #(
        .LINES      (LINES),
        .LINE_WORDS (LINE_WORDS)
    ) u_data (
        .clk   (clk),
        .raddr (look_addr[2 +: DAW]),
        .rdata (look_rdata),
        .we    (dat_we),
        .waddr (dat_addr[2 +: DAW]),
        .wdata (dat_wdata)
    );

endmodule

// File: rtl/cpc_chk.sv
module cpc_chk #(
    parameter int unsigned LINES = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_valid,
    input logic             cpu_ready,
    input logic             purge_line_req,
    input logic             purge_all_req,
    input logic             mem_req,
    input logic             mem_we,
    input logic [31:0]      mem_addr,
    input logic             mem_ack,
    input logic [LINES-1:0] line_valid
);

    // R12
    purge_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (purge_line_req || purge_all_req) |-> !cpu_ready);

    // R11
    purge_all_clear_chk: assert property (@(posedge clk) disable iff (rst)
        purge_all_req |=> (line_valid == '0));

    // R2
    ready_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> (cpu_valid && !mem_req));

    // R3
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

bind cache_purge_ctl cpc_chk #(.LINES(LINES)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_valid      (cpu_valid),
    .cpu_ready      (cpu_ready),
    .purge_line_req (purge_line_req),
    .purge_all_req  (purge_all_req),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_ack        (mem_ack),
    .line_valid     (line_valid)
);

// File: tb/cache_purge_ctl_tb.sv
`timescale 1ns/1ps
module cache_purge_ctl_tb;

    localparam logic [31:0] KEY = 32'h3C5A_9617;

    logic        clk = 1'b0;
    logic        rst;
    logic        ctl_ionly;
    logic        cpu_valid, cpu_ready, cpu_write, cpu_ifetch, cpu_atomic;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        purge_line_req, purge_all_req;
    logic [31:0] purge_addr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    logic [31:0] rd_hist [8];
    logic [31:0] last_wa, last_wd;
    logic [31:0] ovl [logic [31:0]];

    cache_purge_ctl u_dut (
        .clk(clk), .rst(rst), .ctl_ionly(ctl_ionly),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_write(cpu_write),
        .cpu_ifetch(cpu_ifetch), .cpu_atomic(cpu_atomic), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .purge_line_req(purge_line_req), .purge_addr(purge_addr),
        .purge_all_req(purge_all_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    initial forever #2.5 clk = ~clk;

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        if (ovl.exists(w)) return ovl[w];
        return w ^ KEY;
    endfunction

    // External memory: acknowledges one word per cycle while requested.
    initial begin
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = mem_req;
            if (mem_req) begin
                if (mem_we) begin
                    ovl[{mem_addr[31:2], 2'b00}] = mem_wdata;
                    last_wa = mem_addr;
                    last_wd = mem_wdata;
                    n_wr++;
                end else begin
                    mem_rdata = mem_val(mem_addr);
                    rd_hist[n_rd % 8] = mem_addr;
                    n_rd++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic ifc, input logic atm,
                          input logic [31:0] a, input logic [31:0] wd,
                          input int pl_cyc, input logic [31:0] pa,
                          output logic [31:0] rd, output int waits);
        int  c;
        bit  got;
        c   = 0;
        got = 0;
        rd  = '0;
        waits = 0;
        @(negedge clk);
        cpu_valid  = 1'b1;
        cpu_write  = wr;
        cpu_ifetch = ifc;
        cpu_atomic = atm;
        cpu_addr   = a;
        cpu_wdata  = wd;
        forever begin
            purge_line_req = (c == pl_cyc);
            purge_addr     = pa;
            #1;
            if (cpu_ready) begin
                rd    = cpu_rdata;
                waits = c;
                got   = 1;
            end
            @(negedge clk);
            purge_line_req = 1'b0;
            if (got) begin
                cpu_valid  = 1'b0;
                cpu_write  = 1'b0;
                cpu_ifetch = 1'b0;
                cpu_atomic = 1'b0;
                break;
            end
            c++;
        end
    endtask

    task automatic rd_plain(input logic [31:0] a, output logic [31:0] rd,
                            output int waits);
        access(1'b0, 1'b0, 1'b0, a, '0, -1, '0, rd, waits);
    endtask

    task automatic purge(input bit all, input logic [31:0] pa);
        @(negedge clk);
        purge_line_req = !all;
        purge_all_req  = all;
        purge_addr     = pa;
        @(negedge clk);
        purge_line_req = 1'b0;
        purge_all_req  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd, a, exp;
        int w, nr0, nw0;
        bit ok;

        rst = 1'b1; ctl_ionly = 1'b0;
        cpu_valid = 0; cpu_write = 0; cpu_ifetch = 0; cpu_atomic = 0;
        cpu_addr = '0; cpu_wdata = '0;
        purge_line_req = 0; purge_all_req = 0; purge_addr = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 idle outputs after reset
        chk(!cpu_ready && !mem_req, "R1", {30'd0, cpu_ready, mem_req}, 32'd0);

        // R3 sweep: every line missed once, four ordered word reads each
        for (int i = 0; i < 64; i++) begin
            a = (i << 4) | ((i % 4) << 2);
            nr0 = n_rd;
            rd_plain(a, rd, w);
            chk(rd == mem_val(a), "R3", rd, mem_val(a));
            chk(n_rd - nr0 == 4, (i == 0) ? "R1" : "R3", n_rd - nr0, 4);
            ok = 1;
            for (int k = 0; k < 4; k++)
                if (rd_hist[(nr0 + k) % 8] != {a[31:4], 2'(k), 2'b00}) ok = 0;
            chk(ok, "R3", rd_hist[nr0 % 8], {a[31:4], 4'h0});
        end

        // R2 sweep: every word of every line hits with no wait
        for (int i = 0; i < 64; i++) begin
            for (int k = 0; k < 4; k++) begin
                a = (i << 4) | (k << 2);
                nr0 = n_rd;
                rd_plain(a, rd, w);
                chk(rd == mem_val(a) && w == 0 && n_rd == nr0, "R2", rd, mem_val(a));
            end
        end

        // R9 another master changes memory; cached copy stays
        a = 32'h0000_0054;
        exp = mem_val(a);
        ovl[a] = 32'hDEAD_0001;
        rd_plain(a, rd, w);
        chk(rd == exp, "R9", rd, exp);

        // R10 purge with same index, other tag: no effect
        purge(0, a | 32'h0000_1000);
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(rd == exp && n_rd == nr0, "R10", rd, exp);
        // R10 matching purge (different word of same line) removes it
        purge(0, 32'h0000_005C);
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(rd == 32'hDEAD_0001 && n_rd - nr0 == 4, "R10", rd, 32'hDEAD_0001);
        nr0 = n_rd;
        rd_plain(32'h0000_0060, rd, w);
        chk(n_rd == nr0, "R10", n_rd - nr0, 0);

        // R11 whole purge: every line misses afterwards
        purge(1, '0);
        for (int i = 0; i < 64; i++) begin
            a = (i << 4) | 32'h8;
            nr0 = n_rd;
            rd_plain(a, rd, w);
            chk(n_rd - nr0 == 4 && rd == mem_val(a), "R11", n_rd - nr0, 4);
        end

        // R7 write hit
        a = 32'h0000_0078;
        nw0 = n_wr; nr0 = n_rd;
        access(1, 0, 0, a, 32'h1234_5678, -1, '0, rd, w);
        chk(n_wr - nw0 == 1 && last_wa == a && last_wd == 32'h1234_5678, "R7", last_wd, 32'h1234_5678);
        rd_plain(a, rd, w);
        chk(rd == 32'h1234_5678 && n_rd == nr0, "R7", rd, 32'h1234_5678);
        // R7 write miss: no allocation, resident line kept
        nw0 = n_wr;
        access(1, 0, 0, 32'h0001_0078, 32'h8765_4321, -1, '0, rd, w);
        chk(n_wr - nw0 == 1 && last_wa == 32'h0001_0078, "R7", last_wa, 32'h0001_0078);
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(rd == 32'h1234_5678 && n_rd == nr0, "R7", rd, 32'h1234_5678);
        rd_plain(32'h0001_0078, rd, w);
        chk(rd == 32'h8765_4321 && n_rd - nr0 == 4, "R7", rd, 32'h8765_4321);

        // R6 uncached window
        a = 32'h2000_0040;
        for (int r = 0; r < 2; r++) begin
            nr0 = n_rd;
            rd_plain(a, rd, w);
            chk(rd == mem_val(a) && n_rd - nr0 == 1, "R6", n_rd - nr0, 1);
        end
        nw0 = n_wr;
        access(1, 0, 0, a, 32'hCAFE_F00D, -1, '0, rd, w);
        chk(n_wr - nw0 == 1 && last_wa == a, "R6", last_wa, a);
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(rd == 32'hCAFE_F00D && n_rd - nr0 == 1, "R6", rd, 32'hCAFE_F00D);

        // R4 instruction-only mode
        @(negedge clk);
        ctl_ionly = 1'b1;
        a = 32'h0010_0090;
        for (int r = 0; r < 2; r++) begin
            nr0 = n_rd;
            rd_plain(a, rd, w);
            chk(rd == mem_val(a) && n_rd - nr0 == 1, "R4", n_rd - nr0, 1);
        end
        a = 32'h0010_00A8;
        nr0 = n_rd;
        access(0, 1, 0, a, '0, -1, '0, rd, w);
        chk(rd == mem_val(a) && n_rd - nr0 == 4, "R4", n_rd - nr0, 4);
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(rd == mem_val(a) && n_rd == nr0, "R4", n_rd - nr0, 0);

        // R5 pre-existing data line still hits
        a = 32'h0000_00C4;
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(rd == mem_val(a) && n_rd == nr0 && w == 0, "R5", rd, mem_val(a));
        @(negedge clk);
        ctl_ionly = 1'b0;

        // R8 atomic on a cached word
        a = 32'h0000_00D0;
        exp = mem_val(a);
        ovl[a] = 32'h0000_0100;
        nr0 = n_rd; nw0 = n_wr;
        access(0, 0, 1, a, '0, -1, '0, rd, w);
        chk(rd == 32'h0000_0100, "R8", rd, 32'h0000_0100);
        chk(n_rd - nr0 == 1 && n_wr - nw0 == 1 && rd_hist[nr0 % 8] == a, "R8", n_rd - nr0, 1);
        chk(last_wa == a && last_wd == 32'h0000_0180, "R8", last_wd, 32'h0000_0180);
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(rd == exp && n_rd == nr0, "R8", rd, exp);
        // R8 atomic on an uncached word allocates nothing
        a = 32'h0004_00D0;
        exp = mem_val(a) | 32'h80;
        access(0, 0, 1, a, '0, -1, '0, rd, w);
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(rd == exp && n_rd - nr0 == 4, "R8", rd, exp);

        // R12 purge of the target line in the request's first cycle
        a = 32'h0000_00E0;
        nr0 = n_rd;
        access(0, 0, 0, a, '0, 0, a, rd, w);
        chk(w > 0 && n_rd - nr0 == 4 && rd == mem_val(a), "R12", n_rd - nr0, 4);
        // R12 purge of another line only stalls one cycle
        a = 32'h0000_00F0;
        nr0 = n_rd;
        access(0, 0, 0, a, '0, 0, 32'h0000_0100, rd, w);
        chk(w == 1 && n_rd == nr0 && rd == mem_val(a), "R12", w, 1);

        // R13 purge lands on the final fill acknowledge
        a = 32'h0040_0114;
        nr0 = n_rd;
        access(0, 0, 0, a, '0, 4, a, rd, w);
        chk(rd == mem_val(a) && n_rd - nr0 == 4, "R13", rd, mem_val(a));
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(n_rd - nr0 == 4, "R13", n_rd - nr0, 4);
        nr0 = n_rd;
        rd_plain(a, rd, w);
        chk(n_rd == nr0 && rd == mem_val(a), "R13", n_rd - nr0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule